// File: doc/BRIEF.md
# Linked-Descriptor 2D DMA Engine

This block is a single-channel memory-to-memory mover. It follows a chain of descriptors held in memory. The register side gives it a descriptor pointer and a start pulse. For each descriptor the engine reads six words and then moves 32-bit words from a source address to a destination address. It then raises completion flags and follows the link to the next descriptor. The chain ends when the link is zero or when the channel enable is low at a descriptor boundary.

Each descriptor can turn address increment on or off separately for the source and the destination. It can replace the source read with zero data, or drop the destination write. It can also select a two-dimensional mode. In that mode the length word packs a row count and a per-row byte count, and the stride word packs two signed 16-bit offsets that are added between rows. The byte counter is not reloaded between rows, so only the first row moves data. The later rows only apply their strides to both addresses.

The engine has one memory master port. A request phase uses valid/ready. Read data comes back on a separate response strobe, and only one transaction is in flight at a time.

Top module: `dma2d_chain`

## Requirements
- R1: After reset, busy, end_flag and irq are low, cur_ptr, src_addr, dst_addr and live_len are zero, and no memory request is issued.
- R2: A descriptor is six words read in order from pointer+0, +4, +8, +12, +16 and +20. They are, in that order: control word, source address, destination address, length, stride and next pointer.
- R3: In normal mode (control bit 1 clear) the length is a byte count. The engine moves that many bytes divided by 4, one word per beat. Each beat reads the source and then writes the destination. After each beat, src_addr advances by 4 if control bit 8 is set and dst_addr advances by 4 if control bit 4 is set; otherwise the address holds.
- R4: With control bit 11 set, the source is not read and every destination write carries zero. The source address still follows bit 8.
- R5: With control bit 7 set, no destination write is issued, but the destination address still follows bit 4.
- R6: In 2D mode (control bit 1 set) the row count is length[29:16] and the byte count is length[15:0]. The destination stride is the signed value stride[31:16] and the source stride is the signed value stride[15:0]. Both strides are added between rows but not after the last row. The byte count is not reloaded for later rows.
- R7: After each beat, live_len shows the remaining bytes. In 2D mode it shows {2'b0, current row count[13:0], remaining bytes[15:0]}. Before the first beat it holds the fetched length word.
- R8: On descriptor completion end_flag sets. If control bit 0 is set, irq also sets. cur_ptr then takes the next-pointer field and the chain continues.
- R9: At each descriptor boundary the engine stops and drops busy if cur_ptr is zero or chan_en is low. A descriptor that has started always runs to its end.
- R10: A pulse on end_clr clears end_flag and a pulse on int_clr clears irq. A set in the same cycle wins over a clear.
- R11: start is ignored when chan_en is low or the engine is busy. ptr_wr loads cur_ptr while the engine is idle.
- R12: A request holds its address, direction and data until ready is high. A write completes when it is accepted. A read completes on mem_rsp_valid, and no new request is made before that.
- R13: The two low bits of the byte count are ignored, so only whole words move.
- R14: A 2D descriptor with a row count of zero moves nothing but still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse from the register block |
| ptr_wr | input | 1 | Load strobe for the descriptor pointer |
| ptr_wdata | input | 32 | Descriptor pointer value |
| chan_en | input | 1 | Channel enable, sampled at descriptor boundaries |
| end_clr | input | 1 | Clears end_flag |
| int_clr | input | 1 | Clears irq |
| busy | output | 1 | Engine is walking a chain |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt request |
| cur_ptr | output | AW | Current descriptor pointer |
| src_addr | output | AW | Live source address |
| dst_addr | output | AW | Live destination address |
| live_len | output | 32 | Live length word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The main transfer is tried with the following descriptor patterns:

- Both addresses incrementing.
- A fixed destination, which shows that each beat overwrites the same word and that the last source word lands there.
- Zero-fill with source reads skipped, and write suppression. These separate the read count from the write count and the address motion from the memory contents.
- A 2D descriptor with a positive source stride and a negative destination stride. Its final addresses and the untouched second row confirm stride-between-rows and the missing reload.
- A zero-row 2D descriptor and an odd byte count, which probe the edges of the counting.
- A two-link chain, an enable drop during a descriptor, and a start while disabled, which separate chain following from boundary stopping.

Memory backpressure and a variable read latency are applied in several of these runs, so the held-request and single-outstanding rules are exercised as well.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int ROWS_W     = 14;
    localparam int STRIDE_W   = 16;

    localparam int CB_IRQ_EN  = 0;
    localparam int CB_TWO_D   = 1;
    localparam int CB_DST_INC = 4;
    localparam int CB_DST_OFF = 7;
    localparam int CB_SRC_INC = 8;
    localparam int CB_SRC_OFF = 11;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CHAIN, ST_FREQ, ST_FWAIT, ST_SETUP, ST_BEAT,
        ST_RREQ, ST_RWAIT, ST_WRITE, ST_ROW, ST_DONE
    } st_e;

    typedef struct packed {
        logic                irq_en;
        logic                two_d;
        logic                src_inc;
        logic                dst_inc;
        logic                src_off;
        logic                dst_off;
        logic [WORD_W-1:0]   row_bytes;
        logic [ROWS_W-1:0]   rows;
        logic [STRIDE_W-1:0] src_stride;
        logic [STRIDE_W-1:0] dst_stride;
    } cfg_t;
endpackage

// File: rtl/dma2d_decode.sv
module dma2d_decode
    import dma2d_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] len_word,
    input  logic [WORD_W-1:0] stride_word,
    output cfg_t              cfg
);
    always_comb begin
        cfg.irq_en  = ctrl_word[CB_IRQ_EN];
        cfg.two_d   = ctrl_word[CB_TWO_D];
        cfg.src_inc = ctrl_word[CB_SRC_INC];
        cfg.dst_inc = ctrl_word[CB_DST_INC];
        cfg.src_off = ctrl_word[CB_SRC_OFF];
        cfg.dst_off = ctrl_word[CB_DST_OFF];
        if (ctrl_word[CB_TWO_D]) begin
            cfg.row_bytes  = {{(WORD_W-16){1'b0}}, len_word[15:2], 2'b00};
            cfg.rows       = len_word[16 +: ROWS_W];
            cfg.src_stride = stride_word[STRIDE_W-1:0];
            cfg.dst_stride = stride_word[WORD_W-1 -: STRIDE_W];
        end else begin
            cfg.row_bytes  = {len_word[WORD_W-1:2], 2'b00};
            cfg.rows       = ROWS_W'(1);
            cfg.src_stride = '0;
            cfg.dst_stride = '0;
        end
    end
endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step
    import dma2d_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]       addr,
    input  logic                inc_en,
    input  logic [STRIDE_W-1:0] stride,
    output logic [AW-1:0]       beat_next,
    output logic [AW-1:0]       row_next
);
    localparam logic [AW-1:0] WORD_STEP = AW'(WORD_W / 8);

    always_comb begin
        beat_next = inc_en ? addr + WORD_STEP : addr;
        row_next  = addr + {{(AW-STRIDE_W){stride[STRIDE_W-1]}}, stride};
    end
endmodule

// File: rtl/dma2d_len_pack.sv
module dma2d_len_pack
    import dma2d_pkg::*;
(
    input  logic              two_d,
    input  logic [ROWS_W-1:0] rows,
    input  logic [WORD_W-1:0] bytes_left,
    output logic [WORD_W-1:0] packed_len
);
    always_comb begin
        if (two_d)
            packed_len = {{(WORD_W-16-ROWS_W){1'b0}}, rows, bytes_left[15:0]};
        else
            packed_len = bytes_left;
    end
endmodule

// File: rtl/dma2d_chain.sv
module dma2d_chain
    import dma2d_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ptr_wr,
    input  logic [WORD_W-1:0] ptr_wdata,
    input  logic              chan_en,
    input  logic              end_clr,
    input  logic              int_clr,
    output logic              busy,
    output logic              end_flag,
    output logic              irq,
    output logic [AW-1:0]     cur_ptr,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic [WORD_W-1:0] live_len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
    localparam logic [WORD_W-1:0] BEAT_BYTES = WORD_W'(WORD_W / 8);

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  idx;
        logic [AW-1:0]     ptr;
        logic [WORD_W-1:0] ctrl;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] stride;
        logic [AW-1:0]     nxt;
        logic [WORD_W-1:0] cnt;
        logic [ROWS_W-1:0] rows;
        logic [WORD_W-1:0] data;
        logic              busy;
        logic              endf;
        logic              intf;
    } regs_t;

    regs_t q, d;
    cfg_t  cfg;

    logic [AW-1:0]       a_cur  [2];
    logic                a_inc  [2];
    logic [STRIDE_W-1:0] a_str  [2];
    logic [AW-1:0]       a_beat [2];
    logic [AW-1:0]       a_row  [2];
    logic [WORD_W-1:0]   cnt_after;
    logic [WORD_W-1:0]   len_after;

    dma2d_decode u_dec (
        .ctrl_word   (q.ctrl),
        .len_word    (q.len),
        .stride_word (q.stride),
        .cfg         (cfg)
    );

    // index 0 = source, index 1 = destination
    assign a_cur[0] = q.src;
    assign a_cur[1] = q.dst;
    assign a_inc[0] = cfg.src_inc;
    assign a_inc[1] = cfg.dst_inc;
    assign a_str[0] = cfg.src_stride;
    assign a_str[1] = cfg.dst_stride;

    for (genvar g = 0; g < 2; g++) begin : g_addr
        dma2d_addr_step #(.AW(AW)) u_step (
            .addr      (a_cur[g]),
            .inc_en    (a_inc[g]),
            .stride    (a_str[g]),
            .beat_next (a_beat[g]),
            .row_next  (a_row[g])
        );
    end

    assign cnt_after = q.cnt - BEAT_BYTES;

    dma2d_len_pack u_pack (
        .two_d      (cfg.two_d),
        .rows       (q.rows),
        .bytes_left (cnt_after),
        .packed_len (len_after)
    );

    always_comb begin
        d             = q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        if (end_clr) d.endf = 1'b0;
        if (int_clr) d.intf = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ptr_wr) d.ptr = ptr_wdata[AW-1:0];
                if (start && chan_en) begin
                    d.st   = ST_CHAIN;
                    d.busy = 1'b1;
                end
            end
            ST_CHAIN: begin
                if (!chan_en || q.ptr == '0) begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                end else begin
                    d.st  = ST_FREQ;
                    d.idx = '0;
                end
            end
            ST_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.ptr + {{(AW-IDX_W-2){1'b0}}, q.idx, 2'b00};
                if (mem_req_ready) d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (mem_rsp_valid) begin
                    case (q.idx)
                        IDX_W'(0): d.ctrl   = mem_rsp_rdata;
                        IDX_W'(1): d.src    = mem_rsp_rdata[AW-1:0];
                        IDX_W'(2): d.dst    = mem_rsp_rdata[AW-1:0];
                        IDX_W'(3): d.len    = mem_rsp_rdata;
                        IDX_W'(4): d.stride = mem_rsp_rdata;
                        default:   d.nxt    = mem_rsp_rdata[AW-1:0];
                    endcase
                    if (q.idx == LAST_IDX) begin
                        d.st = ST_SETUP;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = ST_FREQ;
                    end
                end
            end
            ST_SETUP: begin
                d.cnt  = cfg.row_bytes;
                d.rows = cfg.rows;
                d.st   = (cfg.rows == '0) ? ST_DONE : ST_BEAT;
            end
            ST_BEAT: begin
                if (q.cnt == '0) begin
                    d.st = ST_ROW;
                end else if (cfg.src_off) begin
                    d.data = '0;
                    d.st   = ST_WRITE;
                end else begin
                    d.st = ST_RREQ;
                end
            end
            ST_RREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.src;
                if (mem_req_ready) d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rsp_valid) begin
                    d.data = mem_rsp_rdata;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (!cfg.dst_off) begin
                    mem_req_valid = 1'b1;
                    mem_req_write = 1'b1;
                    mem_req_addr  = q.dst;
                    mem_req_wdata = q.data;
                end
                if (cfg.dst_off || mem_req_ready) begin
                    d.src = a_beat[0];
                    d.dst = a_beat[1];
                    d.cnt = cnt_after;
                    d.len = len_after;
                    d.st  = ST_BEAT;
                end
            end
            ST_ROW: begin
                if (q.rows != ROWS_W'(1)) begin
                    d.rows = q.rows - ROWS_W'(1);
                    d.src  = a_row[0];
                    d.dst  = a_row[1];
                    d.st   = ST_BEAT;
                end else begin
                    d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                d.endf = 1'b1;
                if (cfg.irq_en) d.intf = 1'b1;
                d.ptr = q.nxt;
                d.st  = ST_CHAIN;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign end_flag = q.endf;
    assign irq      = q.intf;
    assign cur_ptr  = q.ptr;
    assign src_addr = q.src;
    assign dst_addr = q.dst;
    assign live_len = q.len;

    // R1: no traffic outside a chain walk
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R12: a stalled request keeps its contents
    a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
         && $stable(mem_req_wdata)));

    // R12: read data only arrives while a read is outstanding
    a_r12_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (q.st == ST_FWAIT || q.st == ST_RWAIT));

    // R8: the interrupt line rises only on a descriptor completion
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(q.st == ST_DONE));

    // R9: the engine stops only on a null pointer or a disabled channel
    a_r9_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!chan_en || q.ptr == '0));

    // R7: each completed beat takes one word off the count
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == ST_WRITE) && q.st == ST_BEAT) |->
        (q.cnt == $past(q.cnt) - BEAT_BYTES));
endmodule

// File: tb/sim_dma2d_chain.sv
module sim_dma2d_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        chan_en = 1'b1;
    logic        end_clr = 1'b0;
    logic        int_clr = 1'b0;
    logic        busy, end_flag, irq;
    logic [31:0] cur_ptr, src_addr, dst_addr, live_len;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    dma2d_chain #(.AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_wr(ptr_wr),
        .ptr_wdata(ptr_wdata), .chan_en(chan_en), .end_clr(end_clr),
        .int_clr(int_clr), .busy(busy), .end_flag(end_flag), .irq(irq),
        .cur_ptr(cur_ptr), .src_addr(src_addr), .dst_addr(dst_addr),
        .live_len(live_len), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // memory model: 4 KiB, one outstanding read, optional backpressure
    logic [31:0] mem [0:1023] = '{default: 32'h0};
    logic        bp = 1'b0;
    logic        bd_we = 1'b0;
    logic [31:0] bd_addr = '0;
    logic [31:0] bd_data = '0;
    logic        pend = 1'b0;
    logic [1:0]  pdel = '0;
    logic [31:0] pdata = '0;
    logic [31:0] tick = '0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always @(posedge clk) begin
        tick <= tick + 1;
        mem_req_ready <= bp ? (tick % 3 != 0) : 1'b1;
        mem_rsp_valid <= 1'b0;
        if (bd_we) mem[bd_addr[11:2]] <= bd_data;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[11:2]] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                pend  <= 1'b1;
                pdata <= mem[mem_req_addr[11:2]];
                pdel  <= bp ? {1'b0, tick[0]} : 2'd0;
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (pend) begin
            if (pdel == 2'd0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= pdata;
                pend <= 1'b0;
            end else begin
                pdel <= pdel - 2'd1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bd_write(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = v;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] ctl,
                            input logic [31:0] s, input logic [31:0] dd,
                            input logic [31:0] len, input logic [31:0] str,
                            input logic [31:0] nx);
        bd_write(base,      ctl);
        bd_write(base + 4,  s);
        bd_write(base + 8,  dd);
        bd_write(base + 12, len);
        bd_write(base + 16, str);
        bd_write(base + 20, nx);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        end_clr = 1'b1; int_clr = 1'b1;
        @(negedge clk);
        end_clr = 1'b0; int_clr = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] p);
        int n;
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = p;
        @(negedge clk);
        ptr_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk("run timeout", 32'd1, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 end_flag", {31'b0, end_flag}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 cur_ptr", cur_ptr, 32'd0);
        chk("R1 live_len", live_len, 32'd0);
        chk("R1 src_addr", src_addr, 32'd0);
        chk("R1 dst_addr", dst_addr, 32'd0);
        chk("R1 no request", {31'b0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_normal_inc();
        int r0, w0;
        bp = 1'b1;
        put_desc(32'h100, 32'h111, 32'h400, 32'h800, 32'd16, 32'h0, 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        run_chain(32'h100);
        for (int i = 0; i < 4; i++)
            chk("R3 copied word", mem[(32'h800 >> 2) + i], 32'hA000_0000 + i);
        chk("R3 src_addr", src_addr, 32'h410);
        chk("R3 dst_addr", dst_addr, 32'h810);
        chk("R2 R12 reads", rd_cnt - r0, 32'd10);
        chk("R12 writes", wr_cnt - w0, 32'd4);
        chk("R7 live_len", live_len, 32'd0);
        chk("R8 end_flag", {31'b0, end_flag}, 32'd1);
        chk("R8 irq", {31'b0, irq}, 32'd1);
        chk("R8 cur_ptr", cur_ptr, 32'd0);
        chk("R9 busy", {31'b0, busy}, 32'd0);
        bp = 1'b0;
    endtask

    task automatic t_clear();
        clear_flags();
        chk("R10 end_flag", {31'b0, end_flag}, 32'd0);
        chk("R10 irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_fixed_dst();
        int w0;
        put_desc(32'h100, 32'h100, 32'h400, 32'h900, 32'd12, 32'h0, 32'h0);
        w0 = wr_cnt;
        run_chain(32'h100);
        chk("R3 fixed dst last word", mem[32'h900 >> 2], 32'hA000_0002);
        chk("R3 fixed dst_addr", dst_addr, 32'h900);
        chk("R3 src_addr", src_addr, 32'h40C);
        chk("R3 writes", wr_cnt - w0, 32'd3);
        chk("R8 no irq when disabled", {31'b0, irq}, 32'd0);
        chk("R8 end_flag", {31'b0, end_flag}, 32'd1);
        clear_flags();
    endtask

    task automatic t_skip_src();
        int r0;
        bd_write(32'hA00, 32'hFFFF_FFFF);
        bd_write(32'hA04, 32'hFFFF_FFFF);
        put_desc(32'h100, 32'h910, 32'h400, 32'hA00, 32'd8, 32'h0, 32'h0);
        r0 = rd_cnt;
        run_chain(32'h100);
        chk("R4 zero word 0", mem[32'hA00 >> 2], 32'h0);
        chk("R4 zero word 1", mem[32'hA04 >> 2], 32'h0);
        chk("R4 only fetch reads", rd_cnt - r0, 32'd6);
        chk("R4 src_addr", src_addr, 32'h408);
        clear_flags();
    endtask

    task automatic t_no_dst();
        int r0, w0;
        bd_write(32'hB00, 32'h5555_5555);
        put_desc(32'h100, 32'h190, 32'h400, 32'hB00, 32'd8, 32'h0, 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        run_chain(32'h100);
        chk("R5 no writes", wr_cnt - w0, 32'd0);
        chk("R5 memory kept", mem[32'hB00 >> 2], 32'h5555_5555);
        chk("R5 dst_addr moves", dst_addr, 32'hB08);
        chk("R5 reads", rd_cnt - r0, 32'd8);
        clear_flags();
    endtask

    task automatic t_two_d();
        int w0;
        bp = 1'b1;
        put_desc(32'h100, 32'h112, 32'h400, 32'hC00, 32'h0003_0008,
                 32'hFFF0_0020, 32'h0);
        w0 = wr_cnt;
        run_chain(32'h100);
        chk("R6 row0 word0", mem[32'hC00 >> 2], 32'hA000_0000);
        chk("R6 row0 word1", mem[32'hC04 >> 2], 32'hA000_0001);
        chk("R6 no reload", wr_cnt - w0, 32'd2);
        chk("R6 beyond row untouched", mem[32'hC08 >> 2], 32'h0);
        chk("R6 src stride", src_addr, 32'h448);
        chk("R6 dst stride", dst_addr, 32'hBE8);
        chk("R7 packed live_len", live_len, 32'h0003_0000);
        clear_flags();
        bp = 1'b0;
    endtask

    task automatic t_zero_rows();
        int r0, w0;
        put_desc(32'h100, 32'h112, 32'h400, 32'hD00, 32'h0000_0010, 32'h0, 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        run_chain(32'h100);
        chk("R14 no writes", wr_cnt - w0, 32'd0);
        chk("R14 fetch only", rd_cnt - r0, 32'd6);
        chk("R14 end_flag", {31'b0, end_flag}, 32'd1);
        chk("R7 R14 live_len unchanged", live_len, 32'h0000_0010);
        chk("R14 src_addr", src_addr, 32'h400);
        clear_flags();
    endtask

    task automatic t_odd_len();
        int w0;
        put_desc(32'h100, 32'h110, 32'h400, 32'hE00, 32'd10, 32'h0, 32'h0);
        w0 = wr_cnt;
        run_chain(32'h100);
        chk("R13 whole words", wr_cnt - w0, 32'd2);
        chk("R13 tail untouched", mem[32'hE08 >> 2], 32'h0);
        chk("R13 live_len", live_len, 32'd0);
        clear_flags();
    endtask

    task automatic t_chain();
        int w0;
        put_desc(32'h140, 32'h110, 32'h400, 32'hF00, 32'd4, 32'h0, 32'h180);
        put_desc(32'h180, 32'h111, 32'h404, 32'hF40, 32'd4, 32'h0, 32'h0);
        w0 = wr_cnt;
        run_chain(32'h140);
        chk("R8 first link", mem[32'hF00 >> 2], 32'hA000_0000);
        chk("R8 second link", mem[32'hF40 >> 2], 32'hA000_0001);
        chk("R8 writes", wr_cnt - w0, 32'd2);
        chk("R8 irq from second", {31'b0, irq}, 32'd1);
        chk("R9 null pointer end", cur_ptr, 32'd0);
        clear_flags();
    endtask

    task automatic t_enable_drop();
        bp = 1'b1;
        put_desc(32'h1C0, 32'h110, 32'h400, 32'h600, 32'd32, 32'h0, 32'h200);
        put_desc(32'h200, 32'h110, 32'h400, 32'h700, 32'd4, 32'h0, 32'h0);
        bd_write(32'h700, 32'h0000_1234);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = 32'h1C0;
        @(negedge clk);
        ptr_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chan_en = 1'b0;
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
        chk("R9 stopped", {31'b0, busy}, 32'd0);
        chk("R9 descriptor finished", mem[32'h61C >> 2], 32'hA000_0007);
        chk("R9 pointer kept", cur_ptr, 32'h200);
        chk("R9 next not run", mem[32'h700 >> 2], 32'h0000_1234);
        chan_en = 1'b1;
        bp = 1'b0;
        clear_flags();
    endtask

    task automatic t_start_disabled();
        int w0, r0;
        chan_en = 1'b0;
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = 32'h140;
        @(negedge clk);
        ptr_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 start ignored", {31'b0, busy}, 32'd0);
        chk("R11 no traffic", (rd_cnt - r0) + (wr_cnt - w0), 32'd0);
        chk("R11 pointer loaded", cur_ptr, 32'h140);
        chan_en = 1'b1;
        run_chain(32'h0);
        chk("R9 null start", rd_cnt - r0, 32'd0);
        chk("R9 null start idle", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) bd_write(32'h400 + 4 * i, 32'hA000_0000 + i);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normal_inc();
        t_clear();
        t_fixed_dst();
        t_skip_src();
        t_no_dst();
        t_two_d();
        t_zero_rows();
        t_odd_len();
        t_chain();
        t_enable_drop();
        t_start_disabled();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule